// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block decides, for eight interrupt lines, whether a new interrupt should be raised and which line wins. It takes the raw request, mask and in-service vectors and ranks the lines against a movable priority base: the line named by the rotation offset holds the best rank and the rest follow in ascending line order, wrapping past line 7 back to line 0. The best-ranked pending, unmasked request is raised only when it outranks every line counted as in service.

Two options change which in-service lines count. With special masking on, in-service lines that are also masked drop out of the comparison. With special nesting on, a unit wired as cascade master leaves out the in-service bit of the line that carries the cascaded controller, so a further request from that controller can still be raised. A second output reports the best-ranked in-service line, unfiltered, so end-of-interrupt logic can find which bit to clear. Both results are pure combinational functions of the inputs; the clock and reset only time the built-in checks.

Top module: `rpr_resolver`

## Requirements
- R1: With rotation offset k, rank r (0 best, 7 worst) belongs to line (r + k) mod 8; the winner is the pending line of best rank.
- R2: A line is pending only when its request bit is 1 and its mask bit is 0; a masked request never wins or raises `irq_valid`.
- R3: `irq_valid` is 1 only when the winner's rank is strictly smaller than the best rank among counted in-service lines; an empty counted in-service set has rank 8, so any pending line then wins, and equal rank gives no interrupt.
- R4: With `spec_mask_en` = 1, in-service bits whose mask bit is 1 are not counted; with it 0 every in-service bit is counted.
- R5: When both `spec_nest_en` and `cascade_master` are 1, in-service bit CASCADE_LINE (default 2) is not counted; if either is 0 it is counted.
- R6: When `irq_valid` is 1, `irq_line` carries the winning line number; when it is 0, `irq_line` is 0.
- R7: `isr_top_valid` is 1 whenever any in-service bit is 1 and `isr_top_line` then gives the best-ranked in-service line under the same rotation, independent of mask, special masking and special nesting; with no bit set both are 0.
- R8: Outputs follow input changes within the same cycle, with no register in the path.
- R9: With no pending line, `irq_valid` is 0 whatever the in-service vector holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the built-in checks only |
| rst | input | 1 | Synchronous active-high reset for the built-in checks |
| req_vec | input | 8 | Captured request bits, one per line |
| mask_vec | input | 8 | Mask bits, 1 blocks the line |
| isr_vec | input | 8 | In-service bits, one per line |
| rot_base | input | 3 | Line holding the best rank |
| spec_mask_en | input | 1 | Drop masked lines from the in-service comparison |
| spec_nest_en | input | 1 | Drop the cascade line from the comparison on a master |
| cascade_master | input | 1 | Unit is the cascade master |
| irq_valid | output | 1 | A new interrupt should be raised |
| irq_line | output | 3 | Winning line number |
| isr_top_valid | output | 1 | At least one in-service bit is set |
| isr_top_line | output | 3 | Best-ranked in-service line, for end-of-interrupt use |

## Verification
The raise decision and the end-of-interrupt lookup read the same in-service vector in the same cycle but filter it differently. The bench sets an in-service bit that special masking or special nesting hides, together with a pending request of worse rank, and judges that the interrupt is raised for the request while the lookup still names the hidden in-service line. A sweep over all eight offsets with pseudo-random vectors and option bits compares both results against a loop-based rank model.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
    localparam int LINES = 8;
    localparam int LVL_W = $clog2(LINES);

    typedef logic [LINES-1:0] line_vec_t;
    typedef logic [LVL_W-1:0] line_id_t;
    typedef logic [LVL_W:0]   level_t;

    localparam level_t NO_REQ = level_t'(LINES);

    typedef struct packed {
        logic     hit;
        line_id_t line;
    } grant_t;

    // Best (lowest) rank holding a 1, or NO_REQ when the vector is empty.
    function automatic level_t first_level(line_vec_t v);
        level_t lvl;
        lvl = NO_REQ;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) lvl = level_t'(i);
        end
        return lvl;
    endfunction
endpackage

// File: rtl/rpr_rotate.sv
module rpr_rotate
    import rpr_pkg::*;
(
    input  line_vec_t line_bits,
    input  line_id_t  base,
    output line_vec_t rank_bits
);
    // rank r reads line (r + base), wrapped by the id width
    for (genvar r = 0; r < LINES; r++) begin : g_rank
        line_id_t src;
        assign src          = line_id_t'(r) + base;
        assign rank_bits[r] = line_bits[src];
    end
endmodule

// File: rtl/rpr_rank_pick.sv
module rpr_rank_pick
    import rpr_pkg::*;
(
    input  line_vec_t line_bits,
    input  line_id_t  base,
    output level_t    level,
    output grant_t    grant
);
    line_vec_t ranked;

    rpr_rotate rot_i (
        .line_bits (line_bits),
        .base      (base),
        .rank_bits (ranked)
    );

    always_comb begin
        level      = first_level(ranked);
        grant.hit  = (level != NO_REQ);
        grant.line = grant.hit ? (level[LVL_W-1:0] + base) : '0;
    end
endmodule

// File: rtl/rpr_resolver.sv
module rpr_resolver
    import rpr_pkg::*;
#(
    parameter int CASCADE_LINE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] req_vec,
    input  logic [LINES-1:0] mask_vec,
    input  logic [LINES-1:0] isr_vec,
    input  logic [LVL_W-1:0] rot_base,
    input  logic             spec_mask_en,
    input  logic             spec_nest_en,
    input  logic             cascade_master,
    output logic             irq_valid,
    output logic [LVL_W-1:0] irq_line,
    output logic             isr_top_valid,
    output logic [LVL_W-1:0] isr_top_line
);
    localparam line_vec_t CASC_BIT = line_vec_t'(1) << CASCADE_LINE;

    line_vec_t pend_vec;
    line_vec_t svc_vec;
    level_t    pend_lvl, svc_lvl, top_lvl;
    grant_t    pend_g, svc_g, top_g;

    always_comb begin
        pend_vec = req_vec & ~mask_vec;
        svc_vec  = isr_vec;
        if (spec_mask_en)                   svc_vec = svc_vec & ~mask_vec;
        if (spec_nest_en && cascade_master) svc_vec = svc_vec & ~CASC_BIT;
    end

    rpr_rank_pick pend_i (.line_bits(pend_vec), .base(rot_base), .level(pend_lvl), .grant(pend_g));
    rpr_rank_pick svc_i  (.line_bits(svc_vec),  .base(rot_base), .level(svc_lvl),  .grant(svc_g));
    rpr_rank_pick top_i  (.line_bits(isr_vec),  .base(rot_base), .level(top_lvl),  .grant(top_g));

    always_comb begin
        irq_valid     = pend_g.hit && (pend_lvl < svc_lvl);
        irq_line      = irq_valid ? pend_g.line : '0;
        isr_top_valid = top_g.hit;
        isr_top_line  = top_g.line;
    end

    // R2
    win_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (req_vec[irq_line] && !mask_vec[irq_line]));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((req_vec & ~mask_vec) == '0) |-> !irq_valid);
    // R6
    line_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_valid |-> (irq_line == '0));
    // R7
    top_is_set_chk: assert property (@(posedge clk) disable iff (rst)
        isr_top_valid |-> isr_vec[isr_top_line]);
    // R7
    top_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (isr_vec == '0) |-> (!isr_top_valid && isr_top_line == '0));
    // R3
    no_self_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !spec_mask_en && !(spec_nest_en && cascade_master))
            |-> !isr_vec[irq_line]);
endmodule

// File: tb/rpr_resolver_tb.sv
module rpr_resolver_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_vec = '0, mask_vec = '0, isr_vec = '0;
    logic [2:0] rot_base = '0;
    logic       spec_mask_en = 1'b0, spec_nest_en = 1'b0, cascade_master = 1'b0;
    logic       irq_valid, isr_top_valid;
    logic [2:0] irq_line, isr_top_line;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    rpr_resolver dut_i (
        .clk(clk), .rst(rst), .req_vec(req_vec), .mask_vec(mask_vec),
        .isr_vec(isr_vec), .rot_base(rot_base), .spec_mask_en(spec_mask_en),
        .spec_nest_en(spec_nest_en), .cascade_master(cascade_master),
        .irq_valid(irq_valid), .irq_line(irq_line),
        .isr_top_valid(isr_top_valid), .isr_top_line(isr_top_line)
    );

    function automatic int best_rank(logic [7:0] v, logic [2:0] k);
        for (int r = 0; r < 8; r++) if (v[(r + k) % 8]) return r;
        return 8;
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic apply(logic [7:0] rq, logic [7:0] mk, logic [7:0] is,
                         logic [2:0] k, logic sm, logic sn, logic cm);
        @(negedge clk);
        req_vec = rq; mask_vec = mk; isr_vec = is; rot_base = k;
        spec_mask_en = sm; spec_nest_en = sn; cascade_master = cm;
        #1;
    endtask

    task automatic expect_out(string tag, int v, int ln);
        check({tag, " valid"}, int'(irq_valid), v);
        check({tag, " line"}, int'(irq_line), ln);
    endtask

    task automatic t_reset;
        check("R6 reset valid", int'(irq_valid), 0);
        check("R6 reset line", int'(irq_line), 0);
        check("R7 reset top", int'(isr_top_valid), 0);
    endtask

    task automatic t_rotation;
        apply(8'b1001_0001, 8'h00, 8'h00, 3'd0, 0, 0, 0); expect_out("R1 k0", 1, 0);
        apply(8'b1001_0001, 8'h00, 8'h00, 3'd1, 0, 0, 0); expect_out("R1 k1", 1, 4);
        apply(8'b1001_0001, 8'h00, 8'h00, 3'd5, 0, 0, 0); expect_out("R1 k5", 1, 7);
        apply(8'b1001_0001, 8'h00, 8'h00, 3'd4, 0, 0, 0); expect_out("R1 k4", 1, 4);
        apply(8'b1001_0001, 8'h01, 8'h00, 3'd0, 0, 0, 0); expect_out("R2 mask0", 1, 4);
    endtask

    task automatic t_nesting;
        apply(8'h08, 8'h00, 8'h08, 3'd0, 0, 0, 0); expect_out("R3 equal", 0, 0);
        apply(8'h04, 8'h00, 8'h08, 3'd0, 0, 0, 0); expect_out("R3 better", 1, 2);
        apply(8'h20, 8'h00, 8'h08, 3'd0, 0, 0, 0); expect_out("R3 worse", 0, 0);
        apply(8'h20, 8'h00, 8'h08, 3'd4, 0, 0, 0); expect_out("R3 rotated", 1, 5);
    endtask

    task automatic t_spec_mask;
        apply(8'h10, 8'h02, 8'h02, 3'd0, 0, 0, 0); expect_out("R4 off", 0, 0);
        check("R7 top smm off", int'(isr_top_line), 1);
        apply(8'h10, 8'h02, 8'h02, 3'd0, 1, 0, 0); expect_out("R4 on", 1, 4);
        check("R7 top smm on", int'(isr_top_line), 1);
        check("R7 top valid", int'(isr_top_valid), 1);
    endtask

    task automatic t_spec_nest;
        apply(8'h20, 8'h00, 8'h04, 3'd0, 0, 1, 1); expect_out("R5 both", 1, 5);
        check("R7 top nest", int'(isr_top_line), 2);
        apply(8'h20, 8'h00, 8'h04, 3'd0, 0, 1, 0); expect_out("R5 slave", 0, 0);
        apply(8'h20, 8'h00, 8'h04, 3'd0, 0, 0, 1); expect_out("R5 plain", 0, 0);
    endtask

    task automatic t_idle;
        apply(8'h3C, 8'h3C, 8'h00, 3'd3, 0, 0, 0); expect_out("R9 masked all", 0, 0);
        apply(8'h00, 8'h00, 8'h81, 3'd1, 0, 0, 0); expect_out("R9 none", 0, 0);
        check("R7 top rotated", int'(isr_top_line), 7);
    endtask

    task automatic t_comb;
        apply(8'h40, 8'h00, 8'h00, 3'd0, 0, 0, 0);
        req_vec = 8'h02; #0.5;
        check("R8 same cycle line", int'(irq_line), 1);
        mask_vec = 8'h02; #0.5;
        check("R8 same cycle mask", int'(irq_valid), 0);
    endtask

    task automatic t_sweep;
        for (int n = 0; n < 150; n++) begin
            logic [7:0] rq, mk, is;
            logic [2:0] sel;
            rq = 8'($urandom); mk = 8'($urandom) & 8'($urandom); is = 8'($urandom) & 8'($urandom);
            sel = 3'($urandom);
            for (int k = 0; k < 8; k++) begin
                logic [7:0] sv;
                int pr, cr, tr;
                apply(rq, mk, is, 3'(k), sel[0], sel[1], sel[2]);
                sv = is;
                if (sel[0]) sv = sv & ~mk;
                if (sel[1] && sel[2]) sv = sv & ~8'h04;
                pr = best_rank(rq & ~mk, 3'(k));
                cr = best_rank(sv, 3'(k));
                tr = best_rank(is, 3'(k));
                expect_out("R1 R3 sweep", (pr < cr) ? 1 : 0, (pr < cr) ? (pr + k) % 8 : 0);
                check("R7 sweep valid", int'(isr_top_valid), (tr < 8) ? 1 : 0);
                check("R7 sweep line", int'(isr_top_line), (tr < 8) ? (tr + k) % 8 : 0);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst = 1'b0;
        t_rotation();
        t_nesting();
        t_spec_mask();
        t_spec_nest();
        t_idle();
        t_comb();
        t_sweep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule